// File: doc/BRIEF.md
# Sixteen-Bit Sliced ALU with Condition Flags

This block is the arithmetic and logic stage of a 16-bit datapath. The operand width is split into four 4-bit slices joined by a ripple carry. Every slice decodes the same function controls: a 4-bit function select, a mode bit and an active-low carry-in. Together these give 16 bitwise functions and 16 sum-based functions. Three extra operations sit beside the slice path and act on operand A only: exchanging its two bytes, shifting it right by one bit, and sign-extending its low byte.

The result is combinational. The negative, zero, carry and overflow flags are computed for every operation and stored in a flag register. That register loads on the rising clock edge when the update strobe is high. A control sequencer presents operands and controls in one cycle, uses the result in the same cycle, and pulses the strobe when the operation's flags are meant to be kept for later conditional decisions.

Top module: `alu16_nzcv`

## Requirements
- R1: With op_i=0 (slice path) and mode_i=1, each result bit is a bitwise function of A and B selected by sel_i: 0 ~A, 1 ~(A|B), 2 ~A&B, 3 all zeros, 4 ~(A&B), 5 ~B, 6 A^B, 7 A&~B, 8 ~A|B, 9 ~(A^B), 10 B, 11 A&B, 12 all ones, 13 A|~B, 14 A|B, 15 A. The C and V flags are written as 0.
- R2: With op_i=0 and mode_i=0, the result is (X + Y + cin) mod 2^16, where cin = ~cin_ni, X = A | (B & sel[0]) | (~B & sel[1]) and Y = (A & ~B & sel[2]) | (A & B & sel[3]), all bitwise. For example, sel 9 gives A+B+cin, and sel 6 with cin_ni=0 gives A-B.
- R3: For the sum functions the carry ripples across all four slices, and the C flag is bit 16 of X + Y + cin.
- R4: For the sum functions, V is 1 exactly when X and Y have the same bit 15 and the result's bit 15 differs from it.
- R5: op_i=1 returns A with its bytes exchanged, {A[7:0], A[15:8]}, and writes C=0 and V=0.
- R6: op_i=2 returns {1'b0, A[15:1]}, writes C = A[0] and V = 0.
- R7: op_i=3 returns {{8{A[7]}}, A[7:0]} and writes C=0 and V=0.
- R8: For every operation, N takes result bit 15 and Z is 1 exactly when all 16 result bits are 0.
- R9: The flag outputs change only on a rising clock edge with flag_we_i=1. With flag_we_i=0 they hold their value for any input.
- R10: rst_ni low clears all four flags at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B |
| op_i | input | 2 | 0 slice path, 1 byte exchange, 2 shift right, 3 sign extend |
| sel_i | input | 4 | Slice function select |
| mode_i | input | 1 | 1 bitwise, 0 sum-based |
| cin_ni | input | 1 | Carry into the lowest slice, active low |
| flag_we_i | input | 1 | Flag register load strobe |
| res_o | output | 16 | Combinational result |
| flag_n_o | output | 1 | Stored negative flag |
| flag_z_o | output | 1 | Stored zero flag |
| flag_c_o | output | 1 | Stored carry flag |
| flag_v_o | output | 1 | Stored overflow flag |

## Verification
All 32 slice functions are run with operands whose bit pairs cover every combination of A and B bits within each nibble. This separates each select code from its neighbours and catches a swapped select bit. The sum functions are also run with both carry-in levels and with carries that must ripple across nibble boundaries, such as 0x000F+1 and 0xFFFF+1. These show that the slice chain is joined in the right order and that the carry flag comes from the top slice. Signed overflow corners such as 0x7FFF+1 and 0x8000-1 tell V apart from C. The side operations use operands whose bytes and end bits differ, so that a wrong byte order, fill bit or shifted-out bit shows. A stretch with the strobe held low, followed by an asynchronous reset, separates held flags from recomputed ones.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  typedef enum logic [1:0] {
    OP_SLICE = 2'd0,
    OP_SWAP  = 2'd1,
    OP_SHR   = 2'd2,
    OP_SEXT  = 2'd3
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/alu_slice4.sv
module alu_slice4 #(
  parameter int unsigned SW = 4
) (
  input  logic [SW-1:0] a_i,
  input  logic [SW-1:0] b_i,
  input  logic [3:0]    sel_i,
  input  logic          mode_i,
  input  logic          cin_i,
  output logic [SW-1:0] f_o,
  output logic          cout_o,
  output logic          x_msb_o,
  output logic          y_msb_o
);
  logic [SW-1:0] x, y, lf;
  logic [SW:0]   sum;

  // sum-based functions decompose as X + Y + cin
  always_comb begin
    x   = a_i | (b_i & {SW{sel_i[0]}}) | (~b_i & {SW{sel_i[1]}});
    y   = (a_i & ~b_i & {SW{sel_i[2]}}) | (a_i & b_i & {SW{sel_i[3]}});
    sum = {1'b0, x} + {1'b0, y} + {{SW{1'b0}}, cin_i};
  end

  always_comb begin
    unique case (sel_i)
      4'd0:  lf = ~a_i;
      4'd1:  lf = ~(a_i | b_i);
      4'd2:  lf = ~a_i & b_i;
      4'd3:  lf = '0;
      4'd4:  lf = ~(a_i & b_i);
      4'd5:  lf = ~b_i;
      4'd6:  lf = a_i ^ b_i;
      4'd7:  lf = a_i & ~b_i;
      4'd8:  lf = ~a_i | b_i;
      4'd9:  lf = ~(a_i ^ b_i);
      4'd10: lf = b_i;
      4'd11: lf = a_i & b_i;
      4'd12: lf = '1;
      4'd13: lf = a_i | ~b_i;
      4'd14: lf = a_i | b_i;
      default: lf = a_i;
    endcase
  end

  assign f_o     = mode_i ? lf : sum[SW-1:0];
  assign cout_o  = sum[SW];
  assign x_msb_o = x[SW-1];
  assign y_msb_o = y[SW-1];
endmodule

// File: rtl/alu16_chain.sv
module alu16_chain #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned SW    = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       sel_i,
  input  logic             mode_i,
  input  logic             cin_ni,
  output logic [WIDTH-1:0] f_o,
  output logic             cout_o,
  output logic             x_msb_o,
  output logic             y_msb_o
);
  localparam int unsigned NSL = WIDTH / SW;

  logic [NSL:0]   carry;
  logic [NSL-1:0] xm, ym;

  assign carry[0] = ~cin_ni;

  for (genvar i = 0; i < NSL; i++) begin : g_slice
    alu_slice4 #(.SW(SW)) u_slice (
      .a_i    (a_i[i*SW +: SW]),
      .b_i    (b_i[i*SW +: SW]),
      .sel_i  (sel_i),
      .mode_i (mode_i),
      .cin_i  (carry[i]),
      .f_o    (f_o[i*SW +: SW]),
      .cout_o (carry[i+1]),
      .x_msb_o(xm[i]),
      .y_msb_o(ym[i])
    );
  end

  assign cout_o  = carry[NSL];
  assign x_msb_o = xm[NSL-1];
  assign y_msb_o = ym[NSL-1];
endmodule

// File: rtl/alu16_side.sv
module alu16_side #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] swap_o,
  output logic [WIDTH-1:0] shr_o,
  output logic             shr_out_o,
  output logic [WIDTH-1:0] sext_o
);
  localparam int unsigned HALF = WIDTH / 2;

  assign swap_o    = {a_i[HALF-1:0], a_i[WIDTH-1:HALF]};
  assign shr_o     = {1'b0, a_i[WIDTH-1:1]};
  assign shr_out_o = a_i[0];
  assign sext_o    = {{HALF{a_i[HALF-1]}}, a_i[HALF-1:0]};
endmodule

// File: rtl/alu16_flags.sv
module alu16_flags
  import alu16_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  alu_op_e          op_i,
  input  logic             mode_i,
  input  logic [WIDTH-1:0] res_i,
  input  logic             cout_i,
  input  logic             x_msb_i,
  input  logic             y_msb_i,
  input  logic             shr_out_i,
  output flags_t           flags_o
);
  flags_t nxt, q;

  always_comb begin
    nxt.n = res_i[WIDTH-1];
    nxt.z = ~|res_i;
    nxt.c = 1'b0;
    nxt.v = 1'b0;
    unique case (op_i)
      OP_SLICE: if (!mode_i) begin
        nxt.c = cout_i;
        nxt.v = (x_msb_i == y_msb_i) && (res_i[WIDTH-1] != x_msb_i);
      end
      OP_SHR:  nxt.c = shr_out_i;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (we_i) q <= nxt;
  end

  assign flags_o = q;
endmodule

// File: rtl/alu16_nzcv.sv
module alu16_nzcv
  import alu16_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned SW    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       op_i,
  input  logic [3:0]       sel_i,
  input  logic             mode_i,
  input  logic             cin_ni,
  input  logic             flag_we_i,
  output logic [WIDTH-1:0] res_o,
  output logic             flag_n_o,
  output logic             flag_z_o,
  output logic             flag_c_o,
  output logic             flag_v_o
);
  alu_op_e          op;
  logic [WIDTH-1:0] slice_f, swap_f, shr_f, sext_f;
  logic             cout, xm, ym, shr_out;
  flags_t           flags;

  assign op = alu_op_e'(op_i);

  alu16_chain #(.WIDTH(WIDTH), .SW(SW)) u_chain (
    .a_i    (a_i),
    .b_i    (b_i),
    .sel_i  (sel_i),
    .mode_i (mode_i),
    .cin_ni (cin_ni),
    .f_o    (slice_f),
    .cout_o (cout),
    .x_msb_o(xm),
    .y_msb_o(ym)
  );

  alu16_side #(.WIDTH(WIDTH)) u_side (
    .a_i      (a_i),
    .swap_o   (swap_f),
    .shr_o    (shr_f),
    .shr_out_o(shr_out),
    .sext_o   (sext_f)
  );

  always_comb begin
    unique case (op)
      OP_SWAP: res_o = swap_f;
      OP_SHR:  res_o = shr_f;
      OP_SEXT: res_o = sext_f;
      default: res_o = slice_f;
    endcase
  end

  alu16_flags #(.WIDTH(WIDTH)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (flag_we_i),
    .op_i     (op),
    .mode_i   (mode_i),
    .res_i    (res_o),
    .cout_i   (cout),
    .x_msb_i  (xm),
    .y_msb_i  (ym),
    .shr_out_i(shr_out),
    .flags_o  (flags)
  );

  assign flag_n_o = flags.n;
  assign flag_z_o = flags.z;
  assign flag_c_o = flags.c;
  assign flag_v_o = flags.v;
endmodule

// File: rtl/alu16_nzcv_chk.sv
module alu16_nzcv_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] a_i,
  input logic [1:0]       op_i,
  input logic             mode_i,
  input logic             flag_we_i,
  input logic [WIDTH-1:0] res_o,
  input logic             flag_n_o,
  input logic             flag_z_o,
  input logic             flag_c_o,
  input logic             flag_v_o
);
  localparam int unsigned HALF = WIDTH / 2;

  p_flags_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_i |=> $stable({flag_n_o, flag_z_o, flag_c_o, flag_v_o}));

  p_zero_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> flag_z_o == ($past(res_o) == '0));

  p_neg_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> flag_n_o == $past(res_o[WIDTH-1]));

  p_shr_carry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_i == 2'd2) |=> flag_c_o == $past(a_i[0]));

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_i != 2'd0) |=> !flag_v_o);

  p_logic_cv_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_i == 2'd0 && mode_i) |=> (!flag_c_o && !flag_v_o));

  always_comb begin
    if (rst_ni && op_i == 2'd1)
      p_swap_r5: assert (res_o == {a_i[HALF-1:0], a_i[WIDTH-1:HALF]});
    if (rst_ni && op_i == 2'd3)
      p_sext_r7: assert (res_o == {{HALF{a_i[HALF-1]}}, a_i[HALF-1:0]});
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)
      p_reset_clear_r10: assert ({flag_n_o, flag_z_o, flag_c_o, flag_v_o} == 4'b0);
  end
endmodule

bind alu16_nzcv alu16_nzcv_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .a_i      (a_i),
  .op_i     (op_i),
  .mode_i   (mode_i),
  .flag_we_i(flag_we_i),
  .res_o    (res_o),
  .flag_n_o (flag_n_o),
  .flag_z_o (flag_z_o),
  .flag_c_o (flag_c_o),
  .flag_v_o (flag_v_o)
);

// File: tb/sim_alu16_nzcv.sv
module sim_alu16_nzcv;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] a_i = '0, b_i = '0;
  logic [1:0]  op_i = '0;
  logic [3:0]  sel_i = '0;
  logic        mode_i = 1'b0, cin_ni = 1'b1, flag_we_i = 1'b0;
  logic [15:0] res_o;
  logic        flag_n_o, flag_z_o, flag_c_o, flag_v_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct {
    logic [15:0] res;
    logic [3:0]  fl;
    string       tag;
  } exp_t;
  exp_t q[$];
  logic [3:0] model_fl = 4'b0;

  always #2.5 clk_i = ~clk_i;

  alu16_nzcv u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .op_i(op_i),
    .sel_i(sel_i), .mode_i(mode_i), .cin_ni(cin_ni), .flag_we_i(flag_we_i),
    .res_o(res_o), .flag_n_o(flag_n_o), .flag_z_o(flag_z_o),
    .flag_c_o(flag_c_o), .flag_v_o(flag_v_o)
  );

  function automatic logic [15:0] logic_fn(input logic [3:0] s, input logic [15:0] a, b);
    case (s)
      4'd0:  return ~a;
      4'd1:  return ~(a | b);
      4'd2:  return ~a & b;
      4'd3:  return 16'h0000;
      4'd4:  return ~(a & b);
      4'd5:  return ~b;
      4'd6:  return a ^ b;
      4'd7:  return a & ~b;
      4'd8:  return ~a | b;
      4'd9:  return ~(a ^ b);
      4'd10: return b;
      4'd11: return a & b;
      4'd12: return 16'hFFFF;
      4'd13: return a | ~b;
      4'd14: return a | b;
      default: return a;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [3:0] sel, input logic md,
                       input logic cn, input logic [15:0] a, input logic [15:0] b,
                       input logic we, input string tag);
    logic [15:0] x, y, r;
    logic [16:0] s;
    logic c, v;
    exp_t e;
    c = 1'b0; v = 1'b0;
    x = a | (b & {16{sel[0]}}) | (~b & {16{sel[1]}});
    y = (a & ~b & {16{sel[2]}}) | (a & b & {16{sel[3]}});
    s = {1'b0, x} + {1'b0, y} + {16'b0, ~cn};
    case (op)
      2'd0: if (md) r = logic_fn(sel, a, b);
            else begin
              r = s[15:0]; c = s[16];
              v = (x[15] == y[15]) && (r[15] != x[15]);
            end
      2'd1: r = {a[7:0], a[15:8]};
      2'd2: begin r = {1'b0, a[15:1]}; c = a[0]; end
      default: r = {{8{a[7]}}, a[7:0]};
    endcase
    if (we) model_fl = {r[15], r == 16'h0, c, v};
    e.res = r; e.fl = model_fl; e.tag = tag;
    @(negedge clk_i);
    a_i = a; b_i = b; op_i = op; sel_i = sel; mode_i = md; cin_ni = cn; flag_we_i = we;
    q.push_back(e);
  endtask

  // monitor: result before the edge is already stable; flags checked just after it
  initial begin
    forever begin
      @(posedge clk_i);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        #1;
        check(e.tag, res_o, e.res, "result");
        check(e.tag, {12'b0, flag_n_o, flag_z_o, flag_c_o, flag_v_o}, {12'b0, e.fl}, "flags NZCV");
      end
    end
  end

  task automatic drain();
    while (q.size() > 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    #1;
    check("R10", {12'b0, flag_n_o, flag_z_o, flag_c_o, flag_v_o}, 16'h0, "flags in reset");
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: every bitwise function, nibbles cover all bit pairs
    for (int s = 0; s < 16; s++) drive(2'd0, 4'(s), 1'b1, 1'b1, 16'hC35A, 16'hAAF0, 1'b1, "R1");
    for (int s = 0; s < 16; s++) drive(2'd0, 4'(s), 1'b1, 1'b0, 16'h00FF, 16'h0F0F, 1'b1, "R1");
    // R2: every sum function, both carry levels
    for (int s = 0; s < 16; s++) begin
      drive(2'd0, 4'(s), 1'b0, 1'b1, 16'h3C5A, 16'h1234, 1'b1, "R2");
      drive(2'd0, 4'(s), 1'b0, 1'b0, 16'h8F01, 16'hF0E7, 1'b1, "R2");
    end
    drive(2'd0, 4'd6, 1'b0, 1'b0, 16'd1000, 16'd1, 1'b1, "R2 subtract");
    // R3: ripple across slices
    drive(2'd0, 4'd9, 1'b0, 1'b1, 16'h000F, 16'h0001, 1'b1, "R3 nibble carry");
    drive(2'd0, 4'd9, 1'b0, 1'b1, 16'hFFFF, 16'h0001, 1'b1, "R3 full carry");
    drive(2'd0, 4'd9, 1'b0, 1'b0, 16'hFFFF, 16'h0000, 1'b1, "R3 carry-in");
    // R4: signed overflow corners
    drive(2'd0, 4'd9, 1'b0, 1'b1, 16'h7FFF, 16'h0001, 1'b1, "R4 pos ovf");
    drive(2'd0, 4'd6, 1'b0, 1'b0, 16'h8000, 16'h0001, 1'b1, "R4 neg ovf");
    drive(2'd0, 4'd9, 1'b0, 1'b1, 16'h8000, 16'h8000, 1'b1, "R4 neg+neg");
    drive(2'd0, 4'd9, 1'b0, 1'b1, 16'h7FFF, 16'h8000, 1'b1, "R4 mixed");
    // R5..R7 side operations
    drive(2'd1, 4'd0, 1'b0, 1'b1, 16'h12F4, 16'h0000, 1'b1, "R5");
    drive(2'd1, 4'd0, 1'b0, 1'b1, 16'h0000, 16'hFFFF, 1'b1, "R5 zero");
    drive(2'd2, 4'd0, 1'b0, 1'b1, 16'h8003, 16'h0000, 1'b1, "R6 odd");
    drive(2'd2, 4'd0, 1'b0, 1'b1, 16'hFFFE, 16'h0000, 1'b1, "R6 even");
    drive(2'd2, 4'd0, 1'b0, 1'b1, 16'h0001, 16'h0000, 1'b1, "R6 to zero");
    drive(2'd3, 4'd0, 1'b0, 1'b1, 16'h1280, 16'h0000, 1'b1, "R7 neg");
    drive(2'd3, 4'd0, 1'b0, 1'b1, 16'hAB7F, 16'h0000, 1'b1, "R7 pos");
    drive(2'd3, 4'd0, 1'b0, 1'b1, 16'hFF00, 16'h0000, 1'b1, "R7 zero R8");
    // R9: set distinct flags, then hold with strobe low
    drive(2'd0, 4'd9, 1'b0, 1'b1, 16'h7FFF, 16'h0001, 1'b1, "R9 load");
    drive(2'd0, 4'd3, 1'b1, 1'b1, 16'h1234, 16'h0000, 1'b0, "R9 hold");
    drive(2'd2, 4'd0, 1'b0, 1'b1, 16'h0001, 16'h0000, 1'b0, "R9 hold");
    drive(2'd0, 4'd9, 1'b0, 1'b1, 16'hFFFF, 16'h0001, 1'b0, "R9 hold");
    drain();
    flag_we_i = 1'b0;

    // R10: asynchronous clear between edges
    drive(2'd0, 4'd9, 1'b0, 1'b1, 16'hFFFF, 16'h0001, 1'b1, "R10 preload");
    drain();
    flag_we_i = 1'b0;
    #0.5 rst_ni = 1'b0;
    #0.5 check("R10", {12'b0, flag_n_o, flag_z_o, flag_c_o, flag_v_o}, 16'h0, "flags after async reset");
    model_fl = 4'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    drive(2'd0, 4'd0, 1'b0, 1'b1, 16'h0000, 16'h0000, 1'b0, "R10 held clear");
    drain();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule